// File: doc/BRIEF.md
# Digital Potentiometer Wiper Control Core

This block is the digital control core of a 256-position digital potentiometer. It keeps a volatile tap register that selects where the wiper sits on the resistor string, and a control register whose only live bit chooses between normal operation and shutdown. A bus front end, which is not part of this block, writes and reads both registers through a simple single-cycle write strobe with an address and a combinational read port.

The block turns the effective tap into one switch enable per tap, so exactly one tap switch is closed in steady state. When the tap moves, the switch for the new tap closes one clock before the switch for the old tap opens. In shutdown every tap switch is open, the high-terminal switch is open, and a separate path ties the wiper to the low terminal. The stored tap is kept for the return to normal operation. A supply-dip event arrives as a digital pulse. If it comes while the block is in shutdown, the tap register returns to mid-scale.

Top module: `dpot_wiper_core`

## Requirements
- R1: After reset the tap register reads 80h, the control register reads 40h, and only tap enable 128 is on.
- R2: A write to address 00h loads the tap register. A read of 00h returns the last value written, including while in shutdown.
- R3: At address 10h only bit 6 (run bit, 1 = normal, 0 = shutdown) can be written. The other bits ignore writes and always read 0.
- R4: Tap enable bit k belongs to code k. Code 00h turns on bit 0 (nearest the low terminal) and code FFh turns on bit 255 (nearest the high terminal).
- R5: When the tap register changes in normal mode, the new enable is on in the first cycle after the write edge together with the old one. The old enable turns off one clock later.
- R6: At most two tap enables are on at any time. In normal mode with an unchanged tap, exactly one is on.
- R7: In shutdown all tap enables are off, the low-terminal path enable is 1 and the high-terminal enable is 0. In normal mode the path enable is 0 and the high-terminal enable is 1.
- R8: Entering and leaving shutdown keeps the tap register. After leaving, only the stored tap's enable is on.
- R9: A supply-dip pulse in shutdown sets the tap register to 80h. In normal mode the pulse has no effect.
- R10: A supply-dip pulse in shutdown wins over a tap write in the same cycle, and the result is 80h.
- R11: Writes to any address other than 00h and 10h change nothing. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_glitch | input | 1 | One-cycle supply-dip event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tap_en | output | 256 | Per-tap switch enables, bit k = code k |
| shut_path_en | output | 1 | Wiper-to-low-terminal shutdown path enable |
| high_term_en | output | 1 | High-terminal connect enable |

## Verification
A corrupted tap register shows up at tap_en in the very next cycle as a wrong or missing enable bit, and at bus_rdata as soon as address 00h is read. A lagging tap copy that is stuck or updates one cycle late shows up as a lost overlap cycle, or as a second enable that stays on past the one-clock window. A control bit that is wrong shows at once as swapped shut_path_en and high_term_en. A preset applied in the wrong mode shows as a tap jump to 128 on the next read or after the return from shutdown. The bench runs a behavioural model beside the block and compares every output every clock, so any of these faults is seen within one cycle of the edge that causes it.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_WIPER = 2'd1,
    SEL_CTRL  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/dpot_rst_sync.sv
module dpot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int TAP_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int WIPER_ADDR = 0,
  parameter int CTRL_ADDR  = 16,
  parameter int RUN_BIT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              glitch,
  output logic [TAP_W-1:0]  wiper_q,
  output logic              run_q,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [TAP_W-1:0] MID_CODE = TAP_W'(1) << (TAP_W - 1);

  reg_sel_e         sel;
  logic [TAP_W-1:0] wiper_d;
  logic             run_d;
  logic             wiper_ce;
  logic             run_ce;

  always_comb begin
    if (addr == ADDR_W'(WIPER_ADDR))     sel = SEL_WIPER;
    else if (addr == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
    else                                 sel = SEL_NONE;
  end

  always_comb begin
    wiper_d  = wiper_q;
    wiper_ce = 1'b0;
    if (wr && sel == SEL_WIPER) begin
      wiper_d  = wdata[TAP_W-1:0];
      wiper_ce = 1'b1;
    end
    if (glitch && !run_q) begin
      wiper_d  = MID_CODE;
      wiper_ce = 1'b1;
    end
  end

  always_comb begin
    run_ce = wr && (sel == SEL_CTRL);
    run_d  = wdata[RUN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= MID_CODE;
      run_q   <= 1'b1;
    end else begin
      if (wiper_ce) wiper_q <= wiper_d;
      if (run_ce)   run_q   <= run_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_WIPER: rdata[TAP_W-1:0] = wiper_q;
      SEL_CTRL:  rdata[RUN_BIT]   = run_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/dpot_tap_decoder.sv
module dpot_tap_decoder #(
  parameter int TAP_W = 8,
  localparam int NTAP = 1 << TAP_W
) (
  input  logic [TAP_W-1:0] code,
  output logic [NTAP-1:0]  onehot
);

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign onehot[k] = (code == TAP_W'(k));
  end

endmodule

// File: rtl/dpot_mbb_seq.sv
module dpot_mbb_seq #(
  parameter int TAP_W = 8,
  localparam int NTAP = 1 << TAP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAP_W-1:0] wiper,
  input  logic             run,
  output logic [NTAP-1:0]  tap_en,
  output logic             shut_path_en,
  output logic             high_term_en
);

  localparam logic [TAP_W-1:0] MID_CODE = TAP_W'(1) << (TAP_W - 1);

  logic [TAP_W-1:0] held_q;
  logic [TAP_W-1:0] held_d;
  logic             held_ce;
  logic [NTAP-1:0]  new_oh;
  logic [NTAP-1:0]  old_oh;

  always_comb begin
    held_ce = (held_q != wiper);
    held_d  = wiper;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= MID_CODE;
    else if (held_ce) held_q <= held_d;
  end

  dpot_tap_decoder #(.TAP_W(TAP_W)) u_dec_new (.code(wiper),  .onehot(new_oh));
  dpot_tap_decoder #(.TAP_W(TAP_W)) u_dec_old (.code(held_q), .onehot(old_oh));

  always_comb begin
    tap_en       = run ? (new_oh | old_oh) : '0;
    shut_path_en = !run;
    high_term_en = run;
  end

endmodule

// File: rtl/dpot_wiper_core.sv
module dpot_wiper_core #(
  parameter int TAP_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int WIPER_ADDR = 0,
  parameter int CTRL_ADDR  = 16,
  parameter int RUN_BIT    = 6,
  localparam int NTAP      = 1 << TAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_glitch,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NTAP-1:0]   tap_en,
  output logic              shut_path_en,
  output logic              high_term_en
);

  logic             rst_sync_n;
  logic [TAP_W-1:0] wiper_q;
  logic             run_q;

  dpot_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dpot_regs #(
    .TAP_W(TAP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WIPER_ADDR(WIPER_ADDR), .CTRL_ADDR(CTRL_ADDR), .RUN_BIT(RUN_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .glitch  (pwr_glitch),
    .wiper_q (wiper_q),
    .run_q   (run_q),
    .rdata   (bus_rdata)
  );

  dpot_mbb_seq #(.TAP_W(TAP_W)) u_mbb (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wiper        (wiper_q),
    .run          (run_q),
    .tap_en       (tap_en),
    .shut_path_en (shut_path_en),
    .high_term_en (high_term_en)
  );

endmodule

// File: rtl/dpot_wiper_core_chk.sv
module dpot_wiper_core_chk #(
  parameter int TAP_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int WIPER_ADDR = 0,
  localparam int NTAP      = 1 << TAP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_glitch,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NTAP-1:0]   tap_en,
  input logic              shut_path_en,
  input logic              high_term_en,
  input logic [TAP_W-1:0]  wiper_q
);

  localparam logic [TAP_W-1:0] MID_CODE = TAP_W'(1) << (TAP_W - 1);

  logic wiper_wr;
  assign wiper_wr = bus_wr && (bus_addr == ADDR_W'(WIPER_ADDR));

  a_r6_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) <= 2);

  a_r6_steady_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (high_term_en && wiper_q == $past(wiper_q)) |->
      ($countones(tap_en) == 1 && tap_en[wiper_q]));

  a_r5_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (high_term_en && wiper_q != $past(wiper_q)) |->
      (tap_en[wiper_q] && tap_en[$past(wiper_q)]));

  a_r7_shutdown_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !high_term_en |-> (tap_en == '0 && shut_path_en));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    shut_path_en != high_term_en);

  a_r9_preset_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_glitch && !high_term_en && !wiper_wr) |=> wiper_q == MID_CODE);

  a_r9_ignored_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_glitch && high_term_en && !wiper_wr) |=> $stable(wiper_q));

  a_r10_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_glitch && !high_term_en && wiper_wr) |=> wiper_q == MID_CODE);

endmodule

bind dpot_wiper_core dpot_wiper_core_chk #(
  .TAP_W(TAP_W), .ADDR_W(ADDR_W), .WIPER_ADDR(WIPER_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .pwr_glitch   (pwr_glitch),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .tap_en       (tap_en),
  .shut_path_en (shut_path_en),
  .high_term_en (high_term_en),
  .wiper_q      (wiper_q)
);

// File: tb/sim_dpot_wiper_core.sv
`timescale 1ns/1ps
module sim_dpot_wiper_core;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr_glitch = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [7:0]   bus_wdata = 8'h00;
  logic [7:0]   bus_rdata;
  logic [255:0] tap_en;
  logic         shut_path_en;
  logic         high_term_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dpot_wiper_core u0 (
    .clk(clk), .rst_n(rst_n), .pwr_glitch(pwr_glitch),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tap_en(tap_en),
    .shut_path_en(shut_path_en), .high_term_en(high_term_en)
  );

  // behavioural reference model
  int m_tap, m_prev, m_run, m_live;

  function automatic logic [255:0] exp_taps();
    logic [255:0] v = '0;
    if (m_run != 0) begin
      v[m_tap]  = 1'b1;
      v[m_prev] = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tap = 128; m_prev = 128; m_run = 1; m_live = 0;
    end else if (m_live < 2) begin
      m_live = m_live + 1;
    end else begin
      int nt, nr;
      nt = m_tap; nr = m_run;
      if (bus_wr && bus_addr == 8'h00) nt = bus_wdata;
      if (bus_wr && bus_addr == 8'h10) nr = bus_wdata[6];
      if (pwr_glitch && m_run == 0) nt = 128;
      m_prev = m_tap; m_tap = nt; m_run = nr;
    end
  end

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 R6 tap enables vs model", tap_en, exp_taps());
      check("R7 terminal enables vs model", {254'd0, shut_path_en, high_term_en},
            {254'd0, (m_run == 0), (m_run != 0)});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic glitch();
    @(negedge clk); pwr_glitch = 1'b1;
    @(negedge clk); pwr_glitch = 1'b0;
  endtask

  task automatic rd(string tag, input logic [7:0] a, input logic [7:0] e);
    @(negedge clk); bus_addr = a; #1;
    check(tag, {248'd0, bus_rdata}, {248'd0, e});
  endtask

  function automatic logic [255:0] bit_at(int k);
    logic [255:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd("R1 tap reset", 8'h00, 8'h80);
    rd("R1 control reset", 8'h10, 8'h40);
    check("R1 tap enable at reset", tap_en, bit_at(128));

    wr(8'h00, 8'h37); settle();
    rd("R2 tap readback", 8'h00, 8'h37);
    check("R4 code 37h", tap_en, bit_at(8'h37));
    wr(8'h00, 8'h00); settle();
    check("R4 code 00h low end", tap_en, bit_at(0));
    wr(8'h00, 8'hFF); settle();
    check("R4 code FFh high end", tap_en, bit_at(255));

    // make-before-break window
    wr(8'h00, 8'h10);
    check("R5 overlap cycle", tap_en, bit_at(8'h10) | bit_at(255));
    @(negedge clk);
    check("R5 old tap released", tap_en, bit_at(8'h10));

    wr(8'h10, 8'hFF); settle();
    rd("R3 reserved bits read 0", 8'h10, 8'h40);
    wr(8'h10, 8'h00); settle();
    rd("R3 run bit cleared", 8'h10, 8'h00);
    check("R7 shutdown taps off", tap_en, '0);
    check("R7 shutdown terminals", {254'd0, shut_path_en, high_term_en}, 256'd2);
    wr(8'h10, 8'hBF); settle();
    rd("R3 reserved write ignored", 8'h10, 8'h00);

    wr(8'h00, 8'h5A); settle();
    rd("R2 readback in shutdown", 8'h00, 8'h5A);
    check("R7 taps stay off", tap_en, '0);
    wr(8'h10, 8'h40); settle();
    check("R8 stored tap restored", tap_en, bit_at(8'h5A));

    glitch(); settle();
    rd("R9 glitch ignored in normal", 8'h00, 8'h5A);
    wr(8'h10, 8'h00); glitch(); settle();
    rd("R9 glitch presets in shutdown", 8'h00, 8'h80);
    wr(8'h10, 8'h40); settle();
    check("R8 R9 restored to mid", tap_en, bit_at(128));

    wr(8'h10, 8'h00);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 8'h22; pwr_glitch = 1'b1;
    @(negedge clk); bus_wr = 1'b0; pwr_glitch = 1'b0;
    rd("R10 glitch beats write", 8'h00, 8'h80);
    wr(8'h10, 8'h40); settle();

    wr(8'h05, 8'h11); wr(8'h11, 8'h00); settle();
    rd("R11 tap untouched", 8'h00, 8'h80);
    rd("R11 control untouched", 8'h10, 8'h40);
    rd("R11 unmapped read", 8'h05, 8'h00);

    // mixed traffic, compared against the model every clock
    begin
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < 300; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        @(negedge clk);
        bus_wr     = lf[0] | lf[1];
        bus_addr   = lf[2] ? 8'h00 : (lf[3] ? 8'h10 : 8'h21);
        bus_wdata  = {lf[4:0], lf[7:5]};
        pwr_glitch = (lf[6:5] == 2'b11);
      end
      @(negedge clk); bus_wr = 1'b0; pwr_glitch = 1'b0;
      settle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule